// File: doc/BRIEF.md
# Interleaved Line Window Bilinear Sampler

This block keeps a sliding window of the most recent lines of a raw pixel stream. It stores that window in four memory banks chosen by the parity of the row and of the column. A second stream supplies fixed-point source coordinates, one per handshake. For each coordinate the block reads the four pixels that surround the sub-pixel location, all in the same cycle, and blends them by bilinear interpolation. It returns one corrected 8-bit intensity per accepted coordinate.

The write side is a two-state machine. `ST_AWAIT_FRAME` is entered at reset and ignores every pixel until one arrives with the start-of-frame marker. That pixel moves the machine to `ST_STREAM`. `ST_STREAM` only loops on itself; a later start-of-frame marker restarts the row and column counters inside it. Coordinates are accepted only in `ST_STREAM`. Acceptance stalls until both source rows have been fully written. A coordinate whose rows have already left the window, or whose right-hand neighbour lies past the last column, yields a fixed border value.

The read path is a two-stage pipeline. Stage one performs the bank read. Stage two performs the crossbar reorder, the interpolation and the output register. Once the needed lines are present, the block sustains one coordinate per clock.

Top module: `ilb_bilinear_sampler`

## Requirements
- R1: A pixel at row r, column c of the frame is stored in bank {r[0], c[0]} at address {r[LN_AW-1:1], c[COL_AW-1:1]}. For any integer position (x0, y0), the crossbar selects top-left (x0,y0), top-right (x0+1,y0), bottom-left (x0,y0+1) and bottom-right (x0+1,y0+1) from those banks.
- R2: Pixels are taken only when `pix_valid` is high, and only in `ST_STREAM` or when `pix_sof` is high. A `pix_sof` pixel is placed at (row 0, column 0). Each other taken pixel goes to the next column. The pixel after a `pix_eol` pixel starts column 0 of the next row. Before the first `pix_sof`, `crd_ready` stays low.
- R3: The coordinate x = `crd_x[COL_AW+FRAC_W-1:FRAC_W]` with fraction fx = `crd_x[FRAC_W-1:0]`, and likewise for y. The result is computed in three steps. First, T = p00·(2^F−fx) + p01·fx and B = p10·(2^F−fx) + p11·fx. Next, V = (T·(2^F−fy) + B·fy + 2^(2F−1)) >> 2F. Finally, V is saturated to 255.
- R4: A coordinate with both fractions zero returns the stored pixel at (x0, y0) unchanged.
- R5: `out_valid` rises exactly two clock edges after the edge that accepts a coordinate. With back-to-back accepted coordinates, one result appears per cycle, in acceptance order.
- R6: Let L be the number of lines completed in the current frame, meaning pixels taken with `pix_eol`. `crd_ready` is high exactly when the state is `ST_STREAM` and either y0+1 < L or y0+LINES <= L.
- R7: A coordinate with y0+LINES <= L at acceptance returns `BORDER` (default 128).
- R8: A coordinate with x0 >= COLS−1 returns `BORDER`.
- R9: A `pix_sof` pixel resets L to 0 (or to 1 if it also carries `pix_eol`). Coordinates then stall until the new frame's lines arrive.
- R10: After reset, `out_valid`, `out_data` and `crd_ready` are 0. `out_data` keeps its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input pixel present |
| pix_data | input | PIX_W | Input pixel intensity |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_eol | input | 1 | Pixel is the last of its line |
| crd_valid | input | 1 | Coordinate present |
| crd_ready | output | 1 | Coordinate accepted this cycle when valid |
| crd_x | input | COL_AW+FRAC_W | Source column, unsigned fixed point |
| crd_y | input | ROW_W+FRAC_W | Source row, unsigned fixed point |
| out_valid | output | 1 | Corrected pixel present |
| out_data | output | PIX_W | Corrected pixel intensity |

## Verification
The bench targets the eviction boundary, where y0 = L−LINES must give the border and y0 = L−LINES+1 must not. A design off by one there would show stale, overwritten pixels or a spurious border. It also targets the last-column border and coordinates that wait on lines still arriving. An early `crd_ready` would blend pixels from a line that is not yet written. The bench checks the fresh-frame stall after a second start marker, where a design that kept its line count would read the previous frame. Finally, it sends back-to-back bursts in which any bubble, crossbar swap or rounding error shows up as a missing, late or wrong result.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
    typedef enum logic {
        ST_AWAIT_FRAME = 1'b0,
        ST_STREAM      = 1'b1
    } wr_state_t;
endpackage

// File: rtl/ilb_bank.sv
module ilb_bank #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // read returns the value held before a same-cycle write
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/ilb_xbar.sv
module ilb_xbar #(
    parameter int DW = 8
) (
    input  logic [3:0][DW-1:0] bank_q,
    input  logic [1:0]         par,
    output logic [3:0][DW-1:0] quad
);
    // quad index: 0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right
    for (genvar k = 0; k < 4; k++) begin : g_pos
        localparam logic [1:0] KID = 2'(k);
        assign quad[k] = bank_q[KID ^ par];
    end
endmodule

// File: rtl/ilb_lerp.sv
module ilb_lerp #(
    parameter int DW = 8,
    parameter int FW = 8
) (
    input  logic [3:0][DW-1:0] quad,
    input  logic [FW-1:0]      fx,
    input  logic [FW-1:0]      fy,
    output logic [DW-1:0]      res
);
    localparam int W    = DW + 2 * FW + 2;
    localparam int ONE  = 1 << FW;
    localparam int HALF = 1 << (2 * FW - 1);
    localparam int MAXV = (1 << DW) - 1;

    logic [W-1:0] wx0, wx1, wy0, wy1, top, bot, acc, shifted;

    always_comb begin
        wx1     = W'(fx);
        wx0     = W'(ONE) - wx1;
        wy1     = W'(fy);
        wy0     = W'(ONE) - wy1;
        top     = W'(quad[0]) * wx0 + W'(quad[1]) * wx1;
        bot     = W'(quad[2]) * wx0 + W'(quad[3]) * wx1;
        acc     = top * wy0 + bot * wy1 + W'(HALF);
        shifted = acc >> (2 * FW);
        res     = (shifted > W'(MAXV)) ? DW'(MAXV) : shifted[DW-1:0];
    end
endmodule

// File: rtl/ilb_bilinear_sampler.sv
module ilb_bilinear_sampler
    import ilb_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COLS   = 64,
    parameter int LINES  = 32,
    parameter int ROW_W  = 9,
    parameter int FRAC_W = 8,
    parameter int BORDER = 128,
    localparam int COL_AW = $clog2(COLS),
    localparam int XW     = COL_AW + FRAC_W,
    localparam int YW     = ROW_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_sof,
    input  logic             pix_eol,
    input  logic             crd_valid,
    output logic             crd_ready,
    input  logic [XW-1:0]    crd_x,
    input  logic [YW-1:0]    crd_y,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data
);
    localparam int LN_AW = $clog2(LINES);
    localparam int BA_W  = (LN_AW - 1) + (COL_AW - 1);

    wr_state_t state_q, state_d;
    logic [ROW_W:0]      wr_row_q;
    logic [COL_AW-1:0]   wr_col_q;
    logic                pix_take;
    logic [ROW_W:0]      pos_row;
    logic [COL_AW-1:0]   pos_col;
    logic [BA_W-1:0]     waddr;

    logic [COL_AW-1:0]   x0;
    logic [FRAC_W-1:0]   fx, fy;
    logic [ROW_W-1:0]    y0;
    logic [ROW_W:0]      y0e;
    logic                have_lines, evicted, accept, x_off;

    // ---------------- write-side state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_AWAIT_FRAME;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAIT_FRAME: if (pix_valid && pix_sof) state_d = ST_STREAM;
            ST_STREAM:      state_d = ST_STREAM;
        endcase
    end

    always_comb begin
        pix_take   = pix_valid && (state_q == ST_STREAM || pix_sof);
        pos_row    = pix_sof ? '0 : wr_row_q;
        pos_col    = pix_sof ? '0 : wr_col_q;
        waddr      = {pos_row[LN_AW-1:1], pos_col[COL_AW-1:1]};
        x0         = crd_x[XW-1:FRAC_W];
        fx         = crd_x[FRAC_W-1:0];
        y0         = crd_y[YW-1:FRAC_W];
        fy         = crd_y[FRAC_W-1:0];
        y0e        = {1'b0, y0};
        have_lines = (y0e + 1'b1) < wr_row_q;
        evicted    = (y0e + (ROW_W+1)'(LINES)) <= wr_row_q;
        x_off      = x0 >= COL_AW'(COLS - 1);
        crd_ready  = (state_q == ST_STREAM) && (have_lines || evicted);
        accept     = crd_valid && crd_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_row_q <= '0;
            wr_col_q <= '0;
        end else if (pix_take) begin
            if (pix_eol) begin
                wr_col_q <= '0;
                wr_row_q <= pos_row + 1'b1;
            end else begin
                wr_col_q <= pos_col + 1'b1;
                wr_row_q <= pos_row;
            end
        end
    end

    // ---------------- parity-interleaved banks ----------------
    logic [3:0][PIX_W-1:0] bank_q;

    for (genvar b = 0; b < 4; b++) begin : g_bank
        localparam logic [1:0] BID = 2'(b);
        logic              we;
        logic [ROW_W-1:0]  rrow;
        logic [COL_AW-1:0] rcol;
        logic [BA_W-1:0]   raddr;

        assign we    = pix_take && (pos_row[0] == BID[1]) && (pos_col[0] == BID[0]);
        assign rrow  = (y0[0] == BID[1]) ? y0 : y0 + 1'b1;
        assign rcol  = (x0[0] == BID[0]) ? x0 : x0 + 1'b1;
        assign raddr = {rrow[LN_AW-1:1], rcol[COL_AW-1:1]};

        ilb_bank #(.DW(PIX_W), .AW(BA_W)) u_bank (
            .clk   (clk),
            .we    (we),
            .waddr (waddr),
            .wdata (pix_data),
            .raddr (raddr),
            .rdata (bank_q[b])
        );
    end

    // ---------------- stage 1: read registered ----------------
    logic              s1_valid, s1_border;
    logic [1:0]        s1_par;
    logic [FRAC_W-1:0] s1_fx, s1_fy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_border <= 1'b0;
            s1_par    <= '0;
            s1_fx     <= '0;
            s1_fy     <= '0;
        end else begin
            s1_valid  <= accept;
            s1_border <= evicted || x_off;
            s1_par    <= {y0[0], x0[0]};
            s1_fx     <= fx;
            s1_fy     <= fy;
        end
    end

    // ---------------- stage 2: reorder, blend, output ----------------
    logic [3:0][PIX_W-1:0] quad;
    logic [PIX_W-1:0]      blend;

    ilb_xbar #(.DW(PIX_W)) u_xbar (
        .bank_q (bank_q),
        .par    (s1_par),
        .quad   (quad)
    );

    ilb_lerp #(.DW(PIX_W), .FW(FRAC_W)) u_lerp (
        .quad (quad),
        .fx   (s1_fx),
        .fy   (s1_fy),
        .res  (blend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= s1_border ? PIX_W'(BORDER) : blend;
            end
        end
    end
endmodule

// File: rtl/ilb_sampler_chk.sv
module ilb_sampler_chk
    import ilb_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int FRAC_W = 8,
    parameter int LINES  = 32,
    parameter int COL_AW = 6,
    parameter int PIX_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pix_valid,
    input logic                    pix_sof,
    input logic                    pix_eol,
    input logic                    crd_valid,
    input logic                    crd_ready,
    input logic [ROW_W+FRAC_W-1:0] crd_y,
    input logic                    out_valid,
    input logic [PIX_W-1:0]        out_data,
    input wr_state_t               state,
    input logic [ROW_W:0]          wr_row,
    input logic [COL_AW-1:0]       wr_col
);
    logic [ROW_W:0] cy;
    assign cy = {1'b0, crd_y[ROW_W+FRAC_W-1:FRAC_W]};

    // R5
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(crd_valid && crd_ready, 2));

    // R6
    ready_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crd_ready |-> state == ST_STREAM);

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crd_valid && crd_ready && (cy + (ROW_W+1)'(LINES) > wr_row))
            |-> (cy + 1'b1 < wr_row));

    // R2
    eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_eol && state == ST_STREAM) |=> wr_col == '0);

    // R9
    sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_sof && !pix_eol) |=> (wr_row == '0 && !crd_ready));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

bind ilb_bilinear_sampler ilb_sampler_chk #(
    .ROW_W  (ROW_W),
    .FRAC_W (FRAC_W),
    .LINES  (LINES),
    .COL_AW (COL_AW),
    .PIX_W  (PIX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .pix_eol   (pix_eol),
    .crd_valid (crd_valid),
    .crd_ready (crd_ready),
    .crd_y     (crd_y),
    .out_valid (out_valid),
    .out_data  (out_data),
    .state     (state_q),
    .wr_row    (wr_row_q),
    .wr_col    (wr_col_q)
);

// File: tb/tb_ilb_bilinear_sampler.sv
module tb_ilb_bilinear_sampler;
    localparam int COLS   = 64;
    localparam int LINES  = 32;
    localparam int ROW_W  = 9;
    localparam int FRAC_W = 8;
    localparam int BORDER = 128;
    localparam int XW     = 6 + FRAC_W;
    localparam int YW     = ROW_W + FRAC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
    logic [7:0] pix_data = '0;
    logic crd_valid = 1'b0;
    logic crd_ready;
    logic [XW-1:0] crd_x = '0;
    logic [YW-1:0] crd_y = '0;
    logic out_valid;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    ilb_bilinear_sampler dut (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof), .pix_eol(pix_eol),
        .crd_valid(crd_valid), .crd_ready(crd_ready), .crd_x(crd_x), .crd_y(crd_y),
        .out_valid(out_valid), .out_data(out_data)
    );

    int checks = 0, fails = 0;
    logic [7:0] img [0:63][0:63];
    int exp_q[$];
    int due_q[$];
    int cyc = 0;
    int lines = 0;
    bit fill = 0;
    int last_out = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int bilin(int x0, int fx, int y0, int fy);
        int top, bot, v;
        top = img[y0][x0] * (256 - fx) + img[y0][x0+1] * fx;
        bot = img[y0+1][x0] * (256 - fx) + img[y0+1][x0+1] * fx;
        v = (top * (256 - fy) + bot * fy + 32768) >>> 16;
        if (v > 255) v = 255;
        return v;
    endfunction

    // monitor: sample away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int x0, y0, fx, fy, ev;
            bit er;
            cyc++;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                chk(out_valid === 1'b1, "R5 out_valid latency", int'(out_valid), 1);
                chk(int'(out_data) == exp_q[0], "R1 R3 R4 R7 R8 out_data", int'(out_data), exp_q[0]);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
            end else if (out_valid) begin
                chk(1'b0, "R5 unexpected out_valid", 1, 0);
            end else begin
                chk(int'(out_data) == last_out, "R10 out_data hold", int'(out_data), last_out);
            end
            last_out = int'(out_data);

            if (crd_valid) begin
                x0 = int'(crd_x >> FRAC_W);
                fx = int'(crd_x[FRAC_W-1:0]);
                y0 = int'(crd_y >> FRAC_W);
                fy = int'(crd_y[FRAC_W-1:0]);
                er = fill && ((y0 + 1 < lines) || (y0 + LINES <= lines));
                chk(crd_ready == er, "R2 R6 R9 crd_ready", int'(crd_ready), int'(er));
                if (crd_ready && er) begin
                    if (y0 + LINES <= lines || x0 >= COLS - 1) ev = BORDER;
                    else ev = bilin(x0, fx, y0, fy);
                    exp_q.push_back(ev);
                    due_q.push_back(cyc + 2);
                end
            end

            if (pix_valid && (fill || pix_sof)) begin
                if (pix_sof) begin
                    fill = 1;
                    lines = 0;
                end
                if (pix_eol) lines++;
            end
        end
    end

    task automatic send_rows(int nrows, bit gaps);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (gaps && ($urandom % 4 == 0)) begin
                    @(posedge clk); #1;
                end
                pix_valid = 1'b1;
                pix_data  = 8'($urandom);
                pix_sof   = (r == 0 && c == 0);
                pix_eol   = (c == COLS - 1);
                img[r][c] = pix_data;
                @(posedge clk); #1;
                pix_valid = 1'b0;
                pix_sof   = 1'b0;
                pix_eol   = 1'b0;
            end
        end
    endtask

    task automatic send_crd(int xi, int xf, int yi, int yf);
        crd_x = XW'((xi << FRAC_W) | xf);
        crd_y = YW'((yi << FRAC_W) | yf);
        crd_valid = 1'b1;
        do @(negedge clk); while (!crd_ready);
        @(posedge clk); #1;
        crd_valid = 1'b0;
    endtask

    task automatic rand_crd(int ymax);
        int fxv, fyv;
        fxv = ($urandom % 4 == 0) ? 0 : int'($urandom % 256);
        fyv = ($urandom % 4 == 0) ? 0 : int'($urandom % 256);
        send_crd(int'($urandom % COLS), fxv, int'($urandom % (ymax + 1)), fyv);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
        chk(out_data == 8'd0, "R10 reset out_data", int'(out_data), 0);
        chk(crd_ready == 1'b0, "R10 reset crd_ready", int'(crd_ready), 0);
        @(posedge clk); #1;

        // R2: pixels before any start marker are ignored, coordinates stall
        crd_x = '0; crd_y = '0; crd_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            pix_valid = 1'b1; pix_data = 8'(i); pix_eol = (i == 2);
            @(posedge clk); #1;
        end
        pix_valid = 1'b0; pix_eol = 1'b0; crd_valid = 1'b0;
        @(posedge clk); #1;

        // frame 1 with random coordinates waiting on arriving lines
        fork
            send_rows(48, 1'b1);
            for (int i = 0; i < 80; i++) rand_crd(46);
        join

        // directed corners
        send_crd(5, 0, 0, 0);        // R7 evicted
        send_crd(3, 77, 16, 9);      // R7 boundary: evicted
        send_crd(3, 77, 17, 9);      // R7 boundary: still in window
        send_crd(10, 0, 40, 0);      // R4 exact pixel
        send_crd(63, 128, 45, 16);   // R8 last column
        send_crd(62, 255, 46, 255);  // R3 max fractions
        send_crd(0, 0, 46, 0);       // R4 left edge

        // frame 2: R9 fresh window, first coordinate must stall
        fork
            send_rows(10, 1'b0);
            begin
                repeat (3) @(posedge clk);
                #1;
                send_crd(7, 40, 0, 200);
            end
        join

        // R5 back-to-back burst
        for (int i = 0; i < 40; i++) rand_crd(8);
        repeat (6) @(posedge clk);
        chk(due_q.size() == 0, "R5 all results delivered", due_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule